// File: doc/BRIEF.md
# Multi-Width Serial Flash Single-Byte Read Sequencer

This block fetches one byte from a serial NOR flash. A start pulse latches the bus configuration, a 32-bit address word and two opcode bytes. The block then runs the whole transfer on a four-line data bus: chip select, a serial clock at half the system clock, an opcode phase, an address phase, a dummy phase and a data phase. When the transfer ends, the received byte is held in an output register. While a read is in flight, `busy` stays high, so it can serve as the self-clearing start bit of a command register. Software polls it, or waits for the one-cycle `done` pulse, and then reads `rd_byte`.

Three read families are supported. A plain one-wire read uses opcode 0x03. A one-wire fast read uses opcode 0x0B. Dual-output and quad-output reads take their opcode from dedicated opcode-byte inputs and may send the address on one, two or four lines. The opcode always travels on one line. The dummy length follows from the mode. The block controls the direction of each data line, so the flash can drive the bus once the dummy phase starts.

Top module: `flash_rd_top`

## Requirements
- R1: After a synchronous active-low reset: chip select is high, the serial clock is low, all output enables are 0, `busy` and `done` are 0, and `rd_byte` is 0x00.
- R2: A `go` pulse while idle raises `busy` on the next clock edge. `busy` falls at the end of the transfer, in the same cycle as a one-cycle `done` pulse. A `go` while `busy` is high is ignored and starts no further transfer.
- R3: Bus-config bits are bit0 dual data, bit1 dual address, bit2 quad data, bit3 quad address, bit4 four-byte address. With bits 0 and 2 both clear, the opcode is 0x0B when `fast_rd` is 1 and 0x03 otherwise. The opcode is sent most significant bit first on io[0], with output enable 4'b0001.
- R4: The address is sent most significant bit first. Three bytes are sent ({b2,b1,b0}) when bit4 is 0, and four bytes ({b3,b2,b1,b0}) when bit4 is 1. Each serial clock carries 1, 2 or 4 bits, placed on io[0], io[1:0] or io[3:0], with the highest-numbered line carrying the most significant bit.
- R5: Dummy clocks: 0 for the plain one-wire read and 8 for the fast read. For dual or quad data, 8 with a one-line address, 4 with a two-line address, and 6 with a four-line address.
- R6: Quad data (bit2) uses `quad_op`, and bit3 selects a four-line address. Otherwise, dual data (bit0) uses `dual_op`, and bit1 selects a two-line address. Quad takes priority when both data bits are set.
- R7: Data bits are captured most significant bit first: on io[1] for a one-wire read, on io[1:0] for dual, and on io[3:0] for quad. The full byte appears on `rd_byte` with `done`.
- R8: During the address phase, the output enable covers exactly the address lines (4'b0001, 4'b0011 or 4'b1111). From the first dummy clock until chip select rises, all enables are 0.
- R9: The serial clock is high for one system cycle per bit clock and is low whenever chip select is high. A transfer has 8 + address clocks + dummy + 8/data-lines rising clock edges (48 for a three-byte fast read).
- R10: An address-width bit takes effect only with its own data width selected. Dual- or quad-address bits without the matching data bit leave the address on one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start request, taken only while idle |
| bus_cfg | input | 5 | Data/address width and address length bits |
| fast_rd | input | 1 | One-wire fast-read select |
| addr_b0 | input | 8 | Address byte 0 (least significant) |
| addr_b1 | input | 8 | Address byte 1 |
| addr_b2 | input | 8 | Address byte 2 |
| addr_b3 | input | 8 | Address byte 3, used in four-byte mode only |
| dual_op | input | 8 | Opcode for dual-output reads |
| quad_op | input | 8 | Opcode for quad-output reads |
| busy | output | 1 | Read in progress (self-clearing start bit) |
| done | output | 1 | One-cycle end-of-read pulse |
| rd_byte | output | 8 | Last received byte |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data lines driven by the block |
| io_oe | output | 4 | Per-line output enable |
| io_in | input | 4 | Data lines sampled from the flash |

## Verification
The assertions assume that reset is held for at least one clock edge before the first `go`, and that the configuration, address and opcode inputs are valid in the cycle where `go` meets an idle block. The bench sets all of them one cycle before raising `go` and holds them steady for the whole transfer. A separate directed case pulses `go` again mid-transfer with a different address to show that the extra request is dropped. The flash model in the bench changes `io_in` only on falling serial-clock edges, so the value captured on each rising edge is never in transition.

// File: rtl/flash_rd_pkg.sv
// Shared types for the flash read sequencer.
// Assumes lane counts are encoded as the plain numbers 1, 2 or 4.
package flash_rd_pkg;

    typedef struct packed {
        logic [7:0] opcode;     // byte sent in the opcode phase
        logic [2:0] a_lanes;    // address lines: 1, 2 or 4
        logic [2:0] d_lanes;    // data lines: 1, 2 or 4
        logic       four_byte;  // send four address bytes
        logic [3:0] dummy;      // dummy serial clocks
    } rd_plan_t;

endpackage

// File: rtl/flash_rd_decode.sv
// Mode decoder: turns bus-config bits and opcode inputs into a transfer plan.
// Assumes nothing about timing; purely combinational. Quad beats dual.
module flash_rd_decode
    import flash_rd_pkg::*;
#(
    parameter logic [7:0] OP_PLAIN  = 8'h03,
    parameter logic [7:0] OP_FAST   = 8'h0B,
    parameter int         FAST_DUMMY = 8,
    parameter int         DUMMY_A1  = 8,
    parameter int         DUMMY_A2  = 4,
    parameter int         DUMMY_A4  = 6
) (
    input  logic [4:0] bus_cfg,
    input  logic       fast_rd,
    input  logic [7:0] dual_op,
    input  logic [7:0] quad_op,
    output rd_plan_t   plan
);

    // Pick opcode, lane counts and dummy length for the requested mode.
    always_comb begin
        plan.four_byte = bus_cfg[4];
        if (bus_cfg[2]) begin
            plan.opcode  = quad_op;
            plan.d_lanes = 3'd4;
            plan.a_lanes = bus_cfg[3] ? 3'd4 : 3'd1;
        end else if (bus_cfg[0]) begin
            plan.opcode  = dual_op;
            plan.d_lanes = 3'd2;
            plan.a_lanes = bus_cfg[1] ? 3'd2 : 3'd1;
        end else begin
            plan.opcode  = fast_rd ? OP_FAST : OP_PLAIN;
            plan.d_lanes = 3'd1;
            plan.a_lanes = 3'd1;
        end
        if (plan.d_lanes != 3'd1) begin
            case (plan.a_lanes)
                3'd4:    plan.dummy = 4'(DUMMY_A4);
                3'd2:    plan.dummy = 4'(DUMMY_A2);
                default: plan.dummy = 4'(DUMMY_A1);
            endcase
        end else begin
            plan.dummy = fast_rd ? 4'(FAST_DUMMY) : 4'd0;
        end
    end

endmodule

// File: rtl/flash_rd_seq.sv
// Phase sequencer: runs opcode, address, dummy and data phases on a 4-line bus.
// Assumes plan and addr_word are valid in the cycle go meets an idle block.
// Serial clock is clk/2; outputs change on sck fall, io_in is taken on sck rise.
module flash_rd_seq
    import flash_rd_pkg::*;
#(
    parameter int MAX_DUMMY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  rd_plan_t    plan,
    input  logic [31:0] addr_word,
    input  logic [3:0]  io_in,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rd_byte,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe
);

    localparam int MAX_CLKS = 8 + 32 + MAX_DUMMY + 8;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    logic             active, ph, done_q;
    logic [CNT_W-1:0] cnt;
    rd_plan_t         plan_q;
    logic [39:0]      tx;
    logic [7:0]       rx, rx_next, rd_q;
    logic [5:0]       abits, addr_clks;
    logic [3:0]       data_clks, a_mask;
    logic [CNT_W-1:0] t_dummy, t_data, last;
    logic             in_cmd, in_addr, in_data;

    // Phase boundaries from the latched plan.
    always_comb begin
        abits = plan_q.four_byte ? 6'd32 : 6'd24;
        case (plan_q.a_lanes)
            3'd4:    begin addr_clks = abits >> 2; a_mask = 4'b1111; end
            3'd2:    begin addr_clks = abits >> 1; a_mask = 4'b0011; end
            default: begin addr_clks = abits;      a_mask = 4'b0001; end
        endcase
        case (plan_q.d_lanes)
            3'd4:    data_clks = 4'd2;
            3'd2:    data_clks = 4'd4;
            default: data_clks = 4'd8;
        endcase
        t_dummy = CNT_W'(8) + CNT_W'(addr_clks);
        t_data  = t_dummy + CNT_W'(plan_q.dummy);
        last    = t_data + CNT_W'(data_clks) - CNT_W'(1);
        in_cmd  = cnt < CNT_W'(8);
        in_addr = !in_cmd && (cnt < t_dummy);
        in_data = cnt >= t_data;
    end

    // Drive data lines and their enables for the current phase.
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (active && in_cmd) begin
            io_out = {3'b000, tx[39]};
            io_oe  = 4'b0001;
        end else if (active && in_addr) begin
            io_oe = a_mask;
            case (plan_q.a_lanes)
                3'd4:    io_out = tx[39:36];
                3'd2:    io_out = {2'b00, tx[39:38]};
                default: io_out = {3'b000, tx[39]};
            endcase
        end
    end

    // Shift sampled lines into the receive byte, top bit first.
    always_comb begin
        case (plan_q.d_lanes)
            3'd4:    rx_next = {rx[3:0], io_in};
            3'd2:    rx_next = {rx[5:0], io_in[1:0]};
            default: rx_next = {rx[6:0], io_in[1]};
        endcase
    end

    // Transfer state: start, half-clock toggle, bit counter, shifters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= 1'b0;
            cnt    <= '0;
            plan_q <= '0;
            tx     <= '0;
            rx     <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    ph     <= 1'b0;
                    cnt    <= '0;
                    plan_q <= plan;
                    tx     <= {plan.opcode,
                               plan.four_byte ? addr_word : {addr_word[23:0], 8'h00}};
                    rx     <= '0;
                end
            end else if (!ph) begin
                ph <= 1'b1;
                if (in_data) rx <= rx_next;
            end else begin
                ph <= 1'b0;
                if (cnt == last) begin
                    active <= 1'b0;
                    done_q <= 1'b1;
                    rd_q   <= rx;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                    if (in_cmd)       tx <= tx << 1;
                    else if (in_addr) tx <= tx << plan_q.a_lanes;
                end
            end
        end
    end

    assign busy     = active;
    assign done     = done_q;
    assign rd_byte  = rd_q;
    assign spi_sck  = ph;
    assign spi_cs_n = ~active;

    // R2
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go && !busy |=> busy);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> done && !busy);
    // R9
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // R9
    sck_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |=> !spi_sck);
    // R3
    cmd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> io_oe == 4'b0001);
    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n && io_oe == 4'b0000 |=> io_oe == 4'b0000);
    // R10
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go && !busy |-> plan.a_lanes <= plan.d_lanes);

endmodule

// File: rtl/flash_rd_top.sv
// Single-byte serial flash read sequencer with 1/2/4-line modes.
// Assumes inputs are held stable from go until done.
module flash_rd_top #(
    parameter logic [7:0] OP_PLAIN   = 8'h03,
    parameter logic [7:0] OP_FAST    = 8'h0B,
    parameter int         FAST_DUMMY = 8,
    parameter int         DUMMY_A1   = 8,
    parameter int         DUMMY_A2   = 4,
    parameter int         DUMMY_A4   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [4:0] bus_cfg,
    input  logic       fast_rd,
    input  logic [7:0] addr_b0,
    input  logic [7:0] addr_b1,
    input  logic [7:0] addr_b2,
    input  logic [7:0] addr_b3,
    input  logic [7:0] dual_op,
    input  logic [7:0] quad_op,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    input  logic [3:0] io_in
);

    import flash_rd_pkg::*;

    localparam int MAX_DUMMY = (FAST_DUMMY > DUMMY_A1) ?
        ((FAST_DUMMY > DUMMY_A4) ? FAST_DUMMY : DUMMY_A4) :
        ((DUMMY_A1 > DUMMY_A4) ? DUMMY_A1 : DUMMY_A4);

    rd_plan_t plan;

    flash_rd_decode #(
        .OP_PLAIN(OP_PLAIN), .OP_FAST(OP_FAST), .FAST_DUMMY(FAST_DUMMY),
        .DUMMY_A1(DUMMY_A1), .DUMMY_A2(DUMMY_A2), .DUMMY_A4(DUMMY_A4)
    ) decode_i (
        .bus_cfg (bus_cfg),
        .fast_rd (fast_rd),
        .dual_op (dual_op),
        .quad_op (quad_op),
        .plan    (plan)
    );

    flash_rd_seq #(
        .MAX_DUMMY(MAX_DUMMY)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .plan      (plan),
        .addr_word ({addr_b3, addr_b2, addr_b1, addr_b0}),
        .io_in     (io_in),
        .busy      (busy),
        .done      (done),
        .rd_byte   (rd_byte),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .io_out    (io_out),
        .io_oe     (io_oe)
    );

endmodule

// File: tb/flash_rd_top_tb_top.sv
// Bench: vector table of modes walked by one loop against a behavioural flash,
// then directed cases for reset and a go request during a transfer.
module flash_rd_top_tb_top;

    localparam logic [7:0] DUAL_OP = 8'h3B;
    localparam logic [7:0] QUAD_OP = 8'h6B;
    localparam int NVEC = 12;
    // {cfg[4:0], fast, opcode, addr lanes, data lanes, dummy, addr bytes}
    localparam logic [26:0] VEC [NVEC] = '{
        {5'b00000, 1'b0, 8'h03,   3'd1, 3'd1, 4'd0, 3'd3},
        {5'b00000, 1'b1, 8'h0B,   3'd1, 3'd1, 4'd8, 3'd3},
        {5'b10000, 1'b0, 8'h03,   3'd1, 3'd1, 4'd0, 3'd4},
        {5'b00001, 1'b0, DUAL_OP, 3'd1, 3'd2, 4'd8, 3'd3},
        {5'b00011, 1'b0, DUAL_OP, 3'd2, 3'd2, 4'd4, 3'd3},
        {5'b00100, 1'b0, QUAD_OP, 3'd1, 3'd4, 4'd8, 3'd3},
        {5'b01100, 1'b0, QUAD_OP, 3'd4, 3'd4, 4'd6, 3'd3},
        {5'b11100, 1'b0, QUAD_OP, 3'd4, 3'd4, 4'd6, 3'd4},
        {5'b00101, 1'b0, QUAD_OP, 3'd1, 3'd4, 4'd8, 3'd3},
        {5'b01010, 1'b0, 8'h03,   3'd1, 3'd1, 4'd0, 3'd3},
        {5'b00010, 1'b1, 8'h0B,   3'd1, 3'd1, 4'd8, 3'd3},
        {5'b10111, 1'b0, QUAD_OP, 3'd1, 3'd4, 4'd8, 3'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [4:0] bus_cfg = '0;
    logic fast_rd = 1'b0;
    logic [7:0] addr_b0 = '0, addr_b1 = '0, addr_b2 = '0, addr_b3 = '0;
    logic busy, done, spi_sck, spi_cs_n;
    logic [7:0] rd_byte;
    logic [3:0] io_out, io_oe;
    logic [3:0] io_in_m = 4'b0000;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    flash_rd_top dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .bus_cfg(bus_cfg), .fast_rd(fast_rd),
        .addr_b0(addr_b0), .addr_b1(addr_b1), .addr_b2(addr_b2), .addr_b3(addr_b3),
        .dual_op(DUAL_OP), .quad_op(QUAD_OP), .busy(busy), .done(done),
        .rd_byte(rd_byte), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in_m)
    );

    // Behavioural flash: expected lane/dummy shape set by the bench per read.
    int m_al = 1, m_dl = 1, m_ab = 3, m_dm = 0;
    int rises = 0, cs_falls = 0;
    logic [7:0] m_op = '0;
    logic [31:0] m_addr = '0;
    bit oe_bad = 1'b0;

    function automatic logic [7:0] data_of(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h96;
    endfunction

    function automatic logic [3:0] mask_of(int n);
        return (n == 4) ? 4'b1111 : (n == 2) ? 4'b0011 : 4'b0001;
    endfunction

    always @(negedge spi_cs_n) begin
        rises = 0; m_op = '0; m_addr = '0; oe_bad = 1'b0;
        cs_falls++;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        int ac;
        ac = m_ab * 8 / m_al;
        if (rises < 8) begin
            if (io_oe !== 4'b0001) oe_bad = 1'b1;
            m_op = {m_op[6:0], io_out[0]};
        end else if (rises < 8 + ac) begin
            if (io_oe !== mask_of(m_al)) oe_bad = 1'b1;
            if (m_al == 4)      m_addr = {m_addr[27:0], io_out};
            else if (m_al == 2) m_addr = {m_addr[29:0], io_out[1:0]};
            else                m_addr = {m_addr[30:0], io_out[0]};
        end else if (io_oe !== 4'b0000) oe_bad = 1'b1;
        rises++;
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        int k;
        logic [7:0] b;
        k = rises - (8 + m_ab * 8 / m_al + m_dm);
        b = data_of(m_addr);
        if (k >= 0 && k < 8 / m_dl) begin
            if (m_dl == 4)      io_in_m = 4'(b >> (4 - 4 * k));
            else if (m_dl == 2) io_in_m = {2'b10, 2'(b >> (6 - 2 * k))};
            else                io_in_m = {2'b01, b[7 - k], ~b[7 - k]};
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Start one read and wait for its done pulse; returns cycles waited.
    task automatic start_and_wait(output int waited);
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        check(busy === 1'b1, "R2 busy after go", 32'(busy), 1);
        waited = 0;
        while (done !== 1'b1 && waited < 400) begin
            @(negedge clk) waited++;
        end
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
        check(spi_sck === 1'b0 && io_oe === 4'b0000, "R1 sck/oe", {27'd0, spi_sck, io_oe}, 0);
        check(busy === 1'b0 && done === 1'b0, "R1 busy/done", {30'd0, busy, done}, 0);
        check(rd_byte === 8'h00, "R1 rd_byte", 32'(rd_byte), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [26:0] v;
            logic [31:0] exp_addr;
            int exp_rises;
            string rq;
            v = VEC[i];
            bus_cfg = v[26:22]; fast_rd = v[21];
            m_al = int'(v[12:10]); m_dl = int'(v[9:7]); m_dm = int'(v[6:3]); m_ab = int'(v[2:0]);
            addr_b0 = 8'h11 + 8'(i * 37); addr_b1 = 8'hC4 ^ 8'(i * 9);
            addr_b2 = 8'h5E + 8'(i);      addr_b3 = 8'hA7 - 8'(i * 5);
            exp_addr = (m_ab == 4) ? {addr_b3, addr_b2, addr_b1, addr_b0}
                                   : {8'h00, addr_b2, addr_b1, addr_b0};
            exp_rises = 8 + m_ab * 8 / m_al + m_dm + 8 / m_dl;
            rq = (i >= 8) ? "R10 R6" : "R3 R6";
            start_and_wait(w);
            check(done === 1'b1 && busy === 1'b0, "R2 done with busy low", {30'd0, done, busy}, 2);
            check(m_op === v[20:13], {rq, " opcode"}, 32'(m_op), 32'(v[20:13]));
            check(m_addr === exp_addr, "R4 address", m_addr, exp_addr);
            check(rises == exp_rises, "R5 R9 clock count", rises, exp_rises);
            check(!oe_bad, "R8 enables", 32'(oe_bad), 0);
            check(rd_byte === data_of(exp_addr), "R7 data byte", 32'(rd_byte), 32'(data_of(exp_addr)));
            @(negedge clk);
            check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R9 idle bus", {30'd0, spi_cs_n, spi_sck}, 2);
        end

        // R2: go during a transfer is ignored
        bus_cfg = 5'b00000; fast_rd = 1'b1;
        m_al = 1; m_dl = 1; m_dm = 8; m_ab = 3;
        addr_b0 = 8'h21; addr_b1 = 8'h43; addr_b2 = 8'h65; addr_b3 = 8'h00;
        cs_falls = 0;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        repeat (20) @(negedge clk);
        addr_b0 = 8'hFE; go = 1'b1;
        @(negedge clk) go = 1'b0;
        w = 0;
        while (done !== 1'b1 && w < 400) begin
            @(negedge clk) w++;
        end
        addr_b0 = 8'h21;
        repeat (10) @(negedge clk);
        check(cs_falls == 1, "R2 single transfer", cs_falls, 1);
        check(m_addr === 32'h00654321, "R2 first address kept", m_addr, 32'h00654321);
        check(busy === 1'b0 && spi_cs_n === 1'b1, "R2 idle after", {30'd0, busy, spi_cs_n}, 1);
        check(rd_byte === data_of(32'h00654321), "R7 held byte", 32'(rd_byte), 32'(data_of(32'h00654321)));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule